// File: doc/BRIEF.md
# Way-Predicting Set-Associative Lookup Unit

This block is the lookup side of a four-way set-associative cache built to spend as little array energy per read as it can. Each set keeps a most-recently-used way number, and a new lookup first opens the tag and data arrays of that one way only. When the guess is right, the read completes after one probe with one way's arrays powered. When the guess is wrong, a second probe opens the three other ways together. That read is one cycle slower than a plain parallel lookup, which would have answered in a single probe.

Refills arrive on their own port and always replace the way that was filled longest ago in the target set. Each set keeps a rotating fill pointer for this. The refilled way becomes the new prediction. Per-way enable outputs show which arrays each probe opens. Three counters report how many reads were resolved by the guess, how many needed the second probe, and how many missed in every way. Writes from the core, the next memory level and coherence are handled elsewhere.

Top module: `wp_cache`

## Requirements
- R1: After reset, `req_ready` is high, `resp_valid` is low, all counters read zero, and every line is invalid, so the first read of any address misses.
- R2: On the cycle after a read is accepted, `tag_en` and `data_en` both equal the one-hot code of the predicted way (bit w set for way w). The predicted way is the stored most-recently-used way of the addressed set, and it is 0 for every set after reset.
- R3: A read whose tag is valid in the predicted way answers on the cycle after acceptance. That answer has `resp_hit`=1, the stored data, and exactly one way enabled.
- R4: A read that misses in the predicted way answers one cycle later. In that later cycle both enable buses equal the complement of the first probe's one-hot code.
- R5: A read that matches no way answers in the second-probe cycle with `resp_hit`=0 and `resp_data`=0.
- R6: Every hit makes the hitting way the prediction for its set. A full miss leaves the prediction unchanged. Each set keeps its own prediction.
- R7: A refill writes tag and data into its set's fill-pointer way. The pointer starts at way 0 and steps 0,1,2,3,0 with each refill of that set. The refill also makes that way the set's prediction.
- R8: `cnt_fast` rises by one for every first-probe hit, `cnt_slow` for every second-probe hit, and `cnt_miss` for every full miss.
- R9: `req_ready` is low exactly in the first-probe cycle of a mispredicted read. In every other cycle it is high.
- R10: While no read is in flight, both enable buses are zero and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | TAG_W+log2(SETS) | Read address, tag above set index |
| req_ready | output | 1 | Read is accepted at this edge when high |
| resp_valid | output | 1 | Read answer present this cycle |
| resp_hit | output | 1 | Answer found the line |
| resp_data | output | DATA_W | Line data on a hit, zero on a miss |
| fill_valid | input | 1 | Refill present |
| fill_addr | input | TAG_W+log2(SETS) | Refill address |
| fill_data | input | DATA_W | Refill line data |
| tag_en | output | WAYS | Tag array enables per way |
| data_en | output | WAYS | Data array enables per way |
| cnt_fast | output | CNT_W | First-probe hit count |
| cnt_slow | output | CNT_W | Second-probe hit count |
| cnt_miss | output | CNT_W | Full miss count |

## Verification
A corrupted prediction register does not corrupt data. Its effect shows at the ports as a changed enable pattern on the first probe, and on a line that should have hit it also shows as an extra stall cycle, both one cycle after acceptance. A wrong fill pointer shows up later, when a read that should hit or miss after a wrap of that set's refills gives the other answer. A faulty probe sequencer shows in the same cycle as either an enable pattern that is neither one-hot nor its complement, or a `req_ready` that disagrees with whether an answer was given.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_FIRST  = 2'd1,
        PS_SECOND = 2'd2
    } probe_state_e;
endpackage

// File: rtl/wp_way_array.sv
// One way of the cache: valid bits, tag store and data store for all sets.
module wp_way_array #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);
    logic [SETS-1:0]   vld_q, vld_d;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] line_q [SETS];

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_data;
        end
    end

    // Only an enabled way may report a match or drive data.
    assign hit      = rd_en && vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign hit_data = hit ? line_q[rd_idx] : '0;
endmodule

// File: rtl/wp_set_state.sv
// Per-set prediction (most recently used way) and rotating refill pointer.
module wp_set_state #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic [WAY_W-1:0] pred_way,
    input  logic             hit_upd,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [WAY_W-1:0] victim_way
);
    logic [WAY_W-1:0] mru_q [SETS];
    logic [WAY_W-1:0] mru_d [SETS];
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] ptr_d [SETS];

    assign pred_way   = mru_q[look_idx];
    assign victim_way = ptr_q[fill_idx];

    always_comb begin
        mru_d = mru_q;
        ptr_d = ptr_q;
        if (hit_upd) mru_d[hit_idx] = hit_way;
        // A refill in the same cycle takes precedence for the prediction.
        if (fill_en) begin
            mru_d[fill_idx] = ptr_q[fill_idx];
            ptr_d[fill_idx] = ptr_q[fill_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mru_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else begin
            mru_q <= mru_d;
            ptr_q <= ptr_d;
        end
    end
endmodule

// File: rtl/wp_counters.sv
// Outcome counters for first-probe hits, second-probe hits and full misses.
module wp_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_fast,
    input  logic             inc_slow,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] cnt_fast,
    output logic [CNT_W-1:0] cnt_slow,
    output logic [CNT_W-1:0] cnt_miss
);
    typedef struct packed {
        logic [CNT_W-1:0] fast;
        logic [CNT_W-1:0] slow;
        logic [CNT_W-1:0] miss;
    } tally_t;

    tally_t tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (inc_fast) tally_d.fast = tally_q.fast + 1'b1;
        if (inc_slow) tally_d.slow = tally_q.slow + 1'b1;
        if (inc_miss) tally_d.miss = tally_q.miss + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tally_q <= '0;
        else        tally_q <= tally_d;
    end

    assign cnt_fast = tally_q.fast;
    assign cnt_slow = tally_q.slow;
    assign cnt_miss = tally_q.miss;
endmodule

// File: rtl/wp_cache.sv
// Way-predicting set-associative lookup: probe the predicted way, then the rest.
module wp_cache
    import wp_cache_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [TAG_W+$clog2(SETS)-1:0]  req_addr,
    output logic                           req_ready,
    output logic                           resp_valid,
    output logic                           resp_hit,
    output logic [DATA_W-1:0]              resp_data,
    input  logic                           fill_valid,
    input  logic [TAG_W+$clog2(SETS)-1:0]  fill_addr,
    input  logic [DATA_W-1:0]              fill_data,
    output logic [WAYS-1:0]                tag_en,
    output logic [WAYS-1:0]                data_en,
    output logic [CNT_W-1:0]               cnt_fast,
    output logic [CNT_W-1:0]               cnt_slow,
    output logic [CNT_W-1:0]               cnt_miss
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        probe_state_e     st;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [WAY_W-1:0] pred;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WAY_W-1:0]  mru_way, victim_way, probe_way, hit_way;
    logic [WAYS-1:0]   way_en, way_hit, pred_oh;
    logic [DATA_W-1:0] way_data [WAYS];
    logic [DATA_W-1:0] merged_data;
    logic              any_hit, hit_upd;
    logic              inc_fast, inc_slow, inc_miss;

    wire [IDX_W-1:0] fill_idx = fill_addr[IDX_W-1:0];
    wire [TAG_W-1:0] fill_tag = fill_addr[IDX_W +: TAG_W];

    // The first probe uses the live prediction; the second uses the one latched.
    assign probe_way = (ctl_q.st == PS_SECOND) ? ctl_q.pred : mru_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) pred_oh[w] = (probe_way == WAY_W'(w));
        case (ctl_q.st)
            PS_FIRST:  way_en = pred_oh;
            PS_SECOND: way_en = ~pred_oh;
            default:   way_en = '0;
        endcase
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            wp_way_array #(
                .SETS  (SETS),
                .TAG_W (TAG_W),
                .DATA_W(DATA_W)
            ) u_way (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_en   (way_en[w]),
                .rd_idx  (ctl_q.idx),
                .rd_tag  (ctl_q.tag),
                .wr_en   (fill_valid && (victim_way == WAY_W'(w))),
                .wr_idx  (fill_idx),
                .wr_tag  (fill_tag),
                .wr_data (fill_data),
                .hit     (way_hit[w]),
                .hit_data(way_data[w])
            );
        end
    endgenerate

    // Lowest matching way wins; data from non-matching ways is already zero.
    always_comb begin
        hit_way     = '0;
        merged_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) hit_way = WAY_W'(w);
            merged_data = merged_data | way_data[w];
        end
    end

    assign any_hit = |way_hit;

    wp_set_state #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (ctl_q.idx),
        .pred_way  (mru_way),
        .hit_upd   (hit_upd),
        .hit_idx   (ctl_q.idx),
        .hit_way   (hit_way),
        .fill_en   (fill_valid),
        .fill_idx  (fill_idx),
        .victim_way(victim_way)
    );

    always_comb begin
        resp_valid = ((ctl_q.st == PS_FIRST) && any_hit) || (ctl_q.st == PS_SECOND);
        resp_hit   = resp_valid && any_hit;
        resp_data  = resp_hit ? merged_data : '0;
        req_ready  = !((ctl_q.st == PS_FIRST) && !any_hit);
        hit_upd    = resp_hit;
        inc_fast   = (ctl_q.st == PS_FIRST) && any_hit;
        inc_slow   = (ctl_q.st == PS_SECOND) && any_hit;
        inc_miss   = (ctl_q.st == PS_SECOND) && !any_hit;

        ctl_d    = ctl_q;
        ctl_d.st = PS_IDLE;
        if ((ctl_q.st == PS_FIRST) && !any_hit) begin
            ctl_d.st   = PS_SECOND;
            ctl_d.pred = mru_way;
        end else if (req_valid && req_ready) begin
            ctl_d.st  = PS_FIRST;
            ctl_d.idx = req_addr[IDX_W-1:0];
            ctl_d.tag = req_addr[IDX_W +: TAG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: PS_IDLE, idx: '0, tag: '0, pred: '0};
        else        ctl_q <= ctl_d;
    end

    assign tag_en  = way_en;
    assign data_en = way_en;

    wp_counters #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_fast(inc_fast),
        .inc_slow(inc_slow),
        .inc_miss(inc_miss),
        .cnt_fast(cnt_fast),
        .cnt_slow(cnt_slow),
        .cnt_miss(cnt_miss)
    );
endmodule

// File: rtl/wp_cache_chk.sv
// Port-level properties of the lookup unit, bound into every instance.
module wp_cache_chk #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic [WAYS-1:0]  tag_en,
    input logic [WAYS-1:0]  data_en,
    input logic [CNT_W-1:0] cnt_fast,
    input logic [CNT_W-1:0] cnt_slow,
    input logic [CNT_W-1:0] cnt_miss
);
    // R2
    en_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_en != '0 |-> ($countones(tag_en) == 1 || $countones(tag_en) == WAYS - 1));

    // R3
    fast_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && $countones(data_en) == 1 |-> resp_hit);

    // R4
    second_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> tag_en == ~$past(tag_en));

    // R9
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> resp_valid && req_ready);

    // R5
    miss_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> $countones(tag_en) == WAYS - 1);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_en == '0 |-> !resp_valid);

    // R8
    fast_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit && $countones(tag_en) == 1 |=>
            cnt_fast == $past(cnt_fast) + 1'b1 && $stable(cnt_slow) && $stable(cnt_miss));

    // R8
    miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |=>
            cnt_miss == $past(cnt_miss) + 1'b1 && $stable(cnt_fast) && $stable(cnt_slow));
endmodule

bind wp_cache wp_cache_chk #(
    .WAYS (WAYS),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .resp_valid(resp_valid),
    .resp_hit  (resp_hit),
    .tag_en    (tag_en),
    .data_en   (data_en),
    .cnt_fast  (cnt_fast),
    .cnt_slow  (cnt_slow),
    .cnt_miss  (cnt_miss)
);

// File: tb/wp_cache_test.sv
module wp_cache_test;
    localparam int WAYS = 4, SETS = 16, TAG_W = 8, DATA_W = 16, CNT_W = 16;
    localparam int ADDR_W = TAG_W + $clog2(SETS);
    localparam logic [1:0] K_FAST = 2'd0, K_SLOW = 2'd1, K_MISS = 2'd2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic req_ready, resp_valid, resp_hit;
    logic [DATA_W-1:0] resp_data;
    logic [WAYS-1:0] tag_en, data_en;
    logic [CNT_W-1:0] cnt_fast, cnt_slow, cnt_miss;

    int checks = 0, failures = 0;

    typedef struct {
        logic [1:0]        pred;
        logic [1:0]        kind;
        logic [DATA_W-1:0] data;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    wp_cache #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .tag_en(tag_en), .data_en(data_en),
        .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] dv(input logic [7:0] t);
        return {t, ~t};
    endfunction

    function automatic logic [ADDR_W-1:0] ad(input logic [7:0] t, input logic [3:0] s);
        return {t, s};
    endfunction

    // Monitor: compares every probe cycle against the head of the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() == 0) begin
                if (resp_valid || tag_en != '0)
                    chk(1'b0, "R10 activity with no read", {tag_en, 3'b0, resp_valid}, 0);
            end else begin
                exp_t e;
                logic [WAYS-1:0] oh;
                e  = exp_q[0];
                oh = WAYS'(1) << e.pred;
                if (resp_valid) begin
                    if (e.kind == K_FAST) begin
                        chk(tag_en == oh && data_en == oh, "R3 single way enabled", {tag_en, data_en}, {oh, oh});
                        chk(resp_hit == 1'b1, "R3 first-probe hit flag", resp_hit, 1);
                        chk(resp_data == e.data, "R3 first-probe data", resp_data, e.data);
                    end else begin
                        chk(tag_en == ~oh && data_en == ~oh, "R4 other ways enabled", {tag_en, data_en}, {~oh, ~oh});
                        if (e.kind == K_SLOW) begin
                            chk(resp_hit == 1'b1, "R4 second-probe hit flag", resp_hit, 1);
                            chk(resp_data == e.data, "R4 second-probe data", resp_data, e.data);
                        end else begin
                            chk(resp_hit == 1'b0, "R5 miss flag", resp_hit, 0);
                            chk(resp_data == '0, "R5 miss data zero", resp_data, 0);
                        end
                    end
                    void'(exp_q.pop_front());
                end else if (tag_en != '0) begin
                    chk(e.kind != K_FAST, "R3 expected answer on first probe", e.kind, K_FAST);
                    chk(tag_en == oh && data_en == oh, "R2 predicted way probed first", {tag_en, data_en}, {oh, oh});
                    chk(req_ready == 1'b0, "R9 stall during first probe", req_ready, 0);
                end
            end
        end
    end

    task automatic lookup(input logic [ADDR_W-1:0] a, input logic [1:0] pred,
                          input logic [1:0] kind, input logic [DATA_W-1:0] d);
        exp_t e;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
        e.pred = pred; e.kind = kind; e.data = d;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic refill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_data  = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 no answer after reset", resp_valid, 0);
        chk(cnt_fast == 0 && cnt_slow == 0 && cnt_miss == 0, "R1 counters zero",
            {cnt_fast, cnt_slow}, 0);
        chk(tag_en == '0 && data_en == '0, "R10 enables idle", {tag_en, data_en}, 0);

        // R1 R5: empty cache misses, prediction 0
        lookup(ad(8'h11, 4'd3), 2'd0, K_MISS, '0);
        // R7: first refill lands in way 0 and becomes the prediction
        refill(ad(8'h11, 4'd3), dv(8'h11));
        lookup(ad(8'h11, 4'd3), 2'd0, K_FAST, dv(8'h11));
        // R7: further refills take ways 1 and 2
        refill(ad(8'h22, 4'd3), dv(8'h22));
        refill(ad(8'h33, 4'd3), dv(8'h33));
        // R4: prediction is way 2, line sits in way 0
        lookup(ad(8'h11, 4'd3), 2'd2, K_SLOW, dv(8'h11));
        // R6: hit moved prediction to way 0
        lookup(ad(8'h11, 4'd3), 2'd0, K_FAST, dv(8'h11));
        lookup(ad(8'h33, 4'd3), 2'd0, K_SLOW, dv(8'h33));
        lookup(ad(8'h22, 4'd3), 2'd2, K_SLOW, dv(8'h22));
        lookup(ad(8'h22, 4'd3), 2'd1, K_FAST, dv(8'h22));
        // R7: fill pointer wraps, 0x55 evicts 0x11 from way 0
        refill(ad(8'h44, 4'd3), dv(8'h44));
        refill(ad(8'h55, 4'd3), dv(8'h55));
        // R6: miss keeps prediction at way 0
        lookup(ad(8'h11, 4'd3), 2'd0, K_MISS, '0);
        lookup(ad(8'h55, 4'd3), 2'd0, K_FAST, dv(8'h55));
        lookup(ad(8'h44, 4'd3), 2'd0, K_SLOW, dv(8'h44));
        // R6: another set is untouched
        lookup(ad(8'h11, 4'd7), 2'd0, K_MISS, '0);

        @(negedge clk);
        // R8 totals
        chk(cnt_fast == 4, "R8 first-probe hit count", cnt_fast, 4);
        chk(cnt_slow == 4, "R8 second-probe hit count", cnt_slow, 4);
        chk(cnt_miss == 3, "R8 miss count", cnt_miss, 3);
        chk(tag_en == '0 && !resp_valid, "R10 quiet at end", {tag_en, 3'b0, resp_valid}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule